// File: doc/BRIEF.md
# Programmable Parallel Port Controller

A host-facing peripheral that gives a processor three 8-bit parallel ports, called A, B and C, together with a configuration register. The host reaches the block through an 8-bit bus with separate read and write data lanes. The block drives a data-valid enable for the read lane in place of a tri-state pin. Access is controlled by an active-low select, active-low read and write strobes, and a 2-bit target address. A write is captured on the clock edge at which select and write are both low. Read data is combinational and has no added latency.

Each port's pins run as plain inputs or plain outputs. The configuration word sets the direction. Port C is split into two nibbles, and each nibble has its own direction. The upper nibble goes with port A and the lower nibble goes with port B. Through the configuration address, the host can also set or clear one port C bit without touching the other bits. Only basic input/output operation is built. The configuration bits that would select strobed or bidirectional operation are stored and read back, but they have no effect on the ports.

Top module: `pio_ctrl`

## Requirements
- R1: While rst_ni is low, the configuration word becomes 0x9B, all output latches clear to 0x00, and every output-enable bit is 0, so all ports act as inputs.
- R2: No write has any effect and bus_oe_o stays 0 while cs_ni is high.
- R3: sel_i uses this encoding: 0 is port A, 1 is port B, 2 is port C and 3 is the configuration word. It applies to both reads and writes.
- R4: A write to address 3 with bit 7 = 1 is a direction word. In that word, bit 4 = 1 makes port A an input, bit 3 = 1 makes the upper nibble of C an input, bit 1 = 1 makes port B an input and bit 0 = 1 makes the lower nibble of C an input. Each enable bit is 1 exactly for pins that are outputs. The enables take the new directions from the cycle after the write.
- R5: A read of address 3 returns the stored word with bit 7 forced to 1. Bits 6:5 and bit 2 are stored and read back, but they do not change any direction, enable or port value.
- R6: A direction word clears to 0x00 the output latch of each port, or port C nibble, that the word configures as output. The latches of input ports keep their values.
- R7: A write to address 3 with bit 7 = 0 loads bit 0 into the port C latch bit whose index is given by bits 3:1. The other port C bits, the configuration word and all enables stay unchanged.
- R8: A read of a port that is an input returns its pins. A read of a port that is an output returns its latch. Port C chooses between pins and latch separately for each nibble.
- R9: A write to address 0, 1 or 2 loads the whole latch of that port, whatever its direction, and the value appears on the port's output from the next cycle.
- R10: bus_oe_o equals (cs_ni low and rd_ni low), and bus_d_o follows sel_i and the current state in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| sel_i | input | 2 | Target address: port A, B, C or configuration |
| bus_d_i | input | 8 | Write data from the host |
| bus_d_o | output | 8 | Read data to the host |
| bus_oe_o | output | 1 | Read data valid (bus drive enable) |
| pa_i | input | 8 | Port A pins in |
| pa_o | output | 8 | Port A output latch |
| pa_oe_o | output | 8 | Port A per-pin output enable |
| pb_i | input | 8 | Port B pins in |
| pb_o | output | 8 | Port B output latch |
| pb_oe_o | output | 8 | Port B per-pin output enable |
| pc_i | input | 8 | Port C pins in |
| pc_o | output | 8 | Port C output latch |
| pc_oe_o | output | 8 | Port C per-pin output enable |

## Verification
A corrupted direction bit shows up on the enable vector of the affected port or nibble in the first cycle after the write that caused it. It also changes what the next read of that port returns, because the read switches between pins and latch. A latch that is wrong, whether from a missed clear, a bit set/reset at the wrong index or a write that leaked past the select, shows up on the matching port output one cycle after the access. Comparing every output against a behavioural model on every clock therefore finds a fault in the cycle after the one that caused it. A fault in the configuration register itself stays hidden until the enables change or the register is read back.

// File: rtl/pio_pkg.sv
package pio_pkg;
  typedef enum logic [1:0] {
    SEL_A    = 2'd0,
    SEL_B    = 2'd1,
    SEL_C    = 2'd2,
    SEL_CTRL = 2'd3
  } sel_e;

  // direction flags: 1 = input
  typedef struct packed {
    logic a_in;
    logic cu_in;
    logic b_in;
    logic cl_in;
  } dir_t;

  localparam logic [7:0] CTRL_RST = 8'h9B;
  localparam int unsigned BIT_MODE  = 7;
  localparam int unsigned BIT_A_IN  = 4;
  localparam int unsigned BIT_CU_IN = 3;
  localparam int unsigned BIT_B_IN  = 1;
  localparam int unsigned BIT_CL_IN = 0;
endpackage

// File: rtl/pio_bus_dec.sv
module pio_bus_dec
  import pio_pkg::*;
(
  input  logic       cs_ni,
  input  logic       rd_ni,
  input  logic       wr_ni,
  input  logic [1:0] sel_i,
  input  logic       mode_bit_i,
  output logic       wr_a_o,
  output logic       wr_b_o,
  output logic       wr_c_o,
  output logic       mode_wr_o,
  output logic       bsr_wr_o,
  output logic       rd_en_o
);
  logic wr_act;
  sel_e sel;

  assign sel    = sel_e'(sel_i);
  assign wr_act = ~cs_ni & ~wr_ni;

  assign wr_a_o    = wr_act & (sel == SEL_A);
  assign wr_b_o    = wr_act & (sel == SEL_B);
  assign wr_c_o    = wr_act & (sel == SEL_C);
  assign mode_wr_o = wr_act & (sel == SEL_CTRL) &  mode_bit_i;
  assign bsr_wr_o  = wr_act & (sel == SEL_CTRL) & ~mode_bit_i;
  assign rd_en_o   = ~cs_ni & ~rd_ni;
endmodule

// File: rtl/pio_cfg_reg.sv
module pio_cfg_reg
  import pio_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] cfg_o,
  output dir_t          dir_o
);
  logic [DW-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= DW'(CTRL_RST);
    end else if (mode_wr_i) begin
      cfg_q <= wdata_i;
      cfg_q[BIT_MODE] <= 1'b1;
    end
  end

  assign cfg_o       = cfg_q;
  assign dir_o.a_in  = cfg_q[BIT_A_IN];
  assign dir_o.cu_in = cfg_q[BIT_CU_IN];
  assign dir_o.b_in  = cfg_q[BIT_B_IN];
  assign dir_o.cl_in = cfg_q[BIT_CL_IN];
endmodule

// File: rtl/pio_port_latch.sv
module pio_port_latch #(
  parameter int unsigned W      = 8,
  parameter bit          HAS_BSR = 1'b0,
  localparam int unsigned H     = W / 2,
  localparam int unsigned IW    = $clog2(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          clr_lo_i,
  input  logic          clr_hi_i,
  input  logic          bsr_en_i,
  input  logic [IW-1:0] bsr_idx_i,
  input  logic          bsr_val_i,
  output logic [W-1:0]  q_o
);
  logic [W-1:0] q, nxt;

  always_comb begin
    nxt = q;
    if (wr_en_i) nxt = wdata_i;
    if (clr_hi_i) nxt[W-1:H] = '0;
    if (clr_lo_i) nxt[H-1:0] = '0;
    if (HAS_BSR && bsr_en_i) nxt[bsr_idx_i] = bsr_val_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= nxt;
  end

  assign q_o = q;
endmodule

// File: rtl/pio_rd_mux.sv
module pio_rd_mux
  import pio_pkg::*;
#(
  parameter int unsigned DW = 8,
  localparam int unsigned H = DW / 2
) (
  input  logic [1:0]    sel_i,
  input  dir_t          dir_i,
  input  logic [DW-1:0] cfg_i,
  input  logic [DW-1:0] pa_pin_i,
  input  logic [DW-1:0] pb_pin_i,
  input  logic [DW-1:0] pc_pin_i,
  input  logic [DW-1:0] pa_q_i,
  input  logic [DW-1:0] pb_q_i,
  input  logic [DW-1:0] pc_q_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] a_v, b_v, c_v;
  logic [1:0]    c_nib_in;

  assign c_nib_in = {dir_i.cu_in, dir_i.cl_in};
  assign a_v = dir_i.a_in ? pa_pin_i : pa_q_i;
  assign b_v = dir_i.b_in ? pb_pin_i : pb_q_i;

  for (genvar n = 0; n < 2; n++) begin : g_cnib
    assign c_v[n*H +: H] = c_nib_in[n] ? pc_pin_i[n*H +: H] : pc_q_i[n*H +: H];
  end

  always_comb begin
    unique case (sel_e'(sel_i))
      SEL_A:    rdata_o = a_v;
      SEL_B:    rdata_o = b_v;
      SEL_C:    rdata_o = c_v;
      default: begin
        rdata_o = cfg_i;
        rdata_o[BIT_MODE] = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/pio_ctrl.sv
module pio_ctrl
  import pio_pkg::*;
#(
  parameter int unsigned DW = 8,
  localparam int unsigned H  = DW / 2,
  localparam int unsigned IW = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          rd_ni,
  input  logic          wr_ni,
  input  logic [1:0]    sel_i,
  input  logic [DW-1:0] bus_d_i,
  output logic [DW-1:0] bus_d_o,
  output logic          bus_oe_o,
  input  logic [DW-1:0] pa_i,
  output logic [DW-1:0] pa_o,
  output logic [DW-1:0] pa_oe_o,
  input  logic [DW-1:0] pb_i,
  output logic [DW-1:0] pb_o,
  output logic [DW-1:0] pb_oe_o,
  input  logic [DW-1:0] pc_i,
  output logic [DW-1:0] pc_o,
  output logic [DW-1:0] pc_oe_o
);
  logic wr_a, wr_b, wr_c, mode_wr, bsr_wr, rd_en;
  logic [DW-1:0] cfg, rdata;
  dir_t dir;

  pio_bus_dec u_dec (
    .cs_ni      (cs_ni),
    .rd_ni      (rd_ni),
    .wr_ni      (wr_ni),
    .sel_i      (sel_i),
    .mode_bit_i (bus_d_i[BIT_MODE]),
    .wr_a_o     (wr_a),
    .wr_b_o     (wr_b),
    .wr_c_o     (wr_c),
    .mode_wr_o  (mode_wr),
    .bsr_wr_o   (bsr_wr),
    .rd_en_o    (rd_en)
  );

  pio_cfg_reg #(.DW(DW)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_wr_i (mode_wr),
    .wdata_i   (bus_d_i),
    .cfg_o     (cfg),
    .dir_o     (dir)
  );

  // clears follow the directions in the incoming word
  logic clr_a, clr_b, clr_cu, clr_cl;
  assign clr_a  = mode_wr & ~bus_d_i[BIT_A_IN];
  assign clr_b  = mode_wr & ~bus_d_i[BIT_B_IN];
  assign clr_cu = mode_wr & ~bus_d_i[BIT_CU_IN];
  assign clr_cl = mode_wr & ~bus_d_i[BIT_CL_IN];

  pio_port_latch #(.W(DW), .HAS_BSR(1'b0)) u_la (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_a),
    .wdata_i   (bus_d_i),
    .clr_lo_i  (clr_a),
    .clr_hi_i  (clr_a),
    .bsr_en_i  (1'b0),
    .bsr_idx_i ('0),
    .bsr_val_i (1'b0),
    .q_o       (pa_o)
  );

  pio_port_latch #(.W(DW), .HAS_BSR(1'b0)) u_lb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_b),
    .wdata_i   (bus_d_i),
    .clr_lo_i  (clr_b),
    .clr_hi_i  (clr_b),
    .bsr_en_i  (1'b0),
    .bsr_idx_i ('0),
    .bsr_val_i (1'b0),
    .q_o       (pb_o)
  );

  pio_port_latch #(.W(DW), .HAS_BSR(1'b1)) u_lc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_c),
    .wdata_i   (bus_d_i),
    .clr_lo_i  (clr_cl),
    .clr_hi_i  (clr_cu),
    .bsr_en_i  (bsr_wr),
    .bsr_idx_i (bus_d_i[IW:1]),
    .bsr_val_i (bus_d_i[0]),
    .q_o       (pc_o)
  );

  pio_rd_mux #(.DW(DW)) u_rd (
    .sel_i    (sel_i),
    .dir_i    (dir),
    .cfg_i    (cfg),
    .pa_pin_i (pa_i),
    .pb_pin_i (pb_i),
    .pc_pin_i (pc_i),
    .pa_q_i   (pa_o),
    .pb_q_i   (pb_o),
    .pc_q_i   (pc_o),
    .rdata_o  (rdata)
  );

  assign bus_d_o  = rdata;
  assign bus_oe_o = rd_en;
  assign pa_oe_o  = {DW{~dir.a_in}};
  assign pb_oe_o  = {DW{~dir.b_in}};
  assign pc_oe_o  = {{H{~dir.cu_in}}, {H{~dir.cl_in}}};
endmodule

// File: rtl/pio_ctrl_chk.sv
module pio_ctrl_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cs_ni,
  input logic          rd_ni,
  input logic          wr_ni,
  input logic [1:0]    sel_i,
  input logic [DW-1:0] bus_d_i,
  input logic [DW-1:0] bus_d_o,
  input logic          bus_oe_o,
  input logic [DW-1:0] pa_i,
  input logic [DW-1:0] pa_o,
  input logic [DW-1:0] pa_oe_o,
  input logic [DW-1:0] pb_i,
  input logic [DW-1:0] pb_o,
  input logic [DW-1:0] pb_oe_o,
  input logic [DW-1:0] pc_i,
  input logic [DW-1:0] pc_o,
  input logic [DW-1:0] pc_oe_o
);
  logic wr_any, mode_w, bsr_w;
  assign wr_any = !cs_ni && !wr_ni;
  assign mode_w = wr_any && sel_i == 2'd3 && bus_d_i[7];
  assign bsr_w  = wr_any && sel_i == 2'd3 && !bus_d_i[7];

  p_no_cs_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> $stable(pa_o) && $stable(pb_o) && $stable(pc_o) && $stable(pc_oe_o) && $stable(pa_oe_o));

  p_dir_a_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_w |=> pa_oe_o == {DW{~$past(bus_d_i[4])}});

  p_dir_b_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_w |=> pb_oe_o == {DW{~$past(bus_d_i[1])}});

  p_cfg_msb_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_oe_o && sel_i == 2'd3) |-> bus_d_o[7]);

  p_clr_a_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_w && !bus_d_i[4]) |=> pa_o == '0);

  p_bsr_bit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bsr_w |=> pc_o[$past(bus_d_i[3:1])] == $past(bus_d_i[0]));

  p_bsr_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bsr_w |=> $stable(pc_oe_o) && $stable(pa_o) && $stable(pb_o) && $countones(pc_o ^ $past(pc_o)) <= 1);

  p_wr_a_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_any && sel_i == 2'd0) |=> pa_o == $past(bus_d_i));

  p_rd_oe_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_oe_o == (!cs_ni && !rd_ni));
endmodule

bind pio_ctrl pio_ctrl_chk #(.DW(DW)) u_chk (.*);

// File: tb/tb_pio_ctrl.sv
module tb_pio_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 20000;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cs_ni = 1'b1, rd_ni = 1'b1, wr_ni = 1'b1;
  logic [1:0] sel = 2'd0;
  logic [7:0] bus_di = 8'h00;
  logic [7:0] pa_pin = 8'hFF, pb_pin = 8'hFF, pc_pin = 8'hFF; // pull-up default
  logic [7:0] bus_do, pa_o, pa_oe, pb_o, pb_oe, pc_o, pc_oe;
  logic bus_oe;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pio_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .rd_ni(rd_ni), .wr_ni(wr_ni),
    .sel_i(sel), .bus_d_i(bus_di), .bus_d_o(bus_do), .bus_oe_o(bus_oe),
    .pa_i(pa_pin), .pa_o(pa_o), .pa_oe_o(pa_oe),
    .pb_i(pb_pin), .pb_o(pb_o), .pb_oe_o(pb_oe),
    .pc_i(pc_pin), .pc_o(pc_o), .pc_oe_o(pc_oe)
  );

  // behavioural reference
  logic [7:0] m_cfg, m_a, m_b, m_c;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cfg <= 8'h9B; m_a <= 0; m_b <= 0; m_c <= 0;
    end else if (!cs_ni && !wr_ni) begin
      case (sel)
        2'd0: m_a <= bus_di;
        2'd1: m_b <= bus_di;
        2'd2: m_c <= bus_di;
        default:
          if (bus_di[7]) begin
            m_cfg <= bus_di;
            if (!bus_di[4]) m_a <= 0;
            if (!bus_di[1]) m_b <= 0;
            m_c <= {bus_di[3] ? m_c[7:4] : 4'h0, bus_di[0] ? m_c[3:0] : 4'h0};
          end else begin
            logic [7:0] t;
            t = m_c;
            t[bus_di[3:1]] = bus_di[0];
            m_c <= t;
          end
      endcase
    end
  end

  function automatic logic [7:0] m_rd(input logic [1:0] s);
    case (s)
      2'd0: return m_cfg[4] ? pa_pin : m_a;
      2'd1: return m_cfg[1] ? pb_pin : m_b;
      2'd2: return {m_cfg[3] ? pc_pin[7:4] : m_c[7:4], m_cfg[0] ? pc_pin[3:0] : m_c[3:0]};
      default: return m_cfg | 8'h80;
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      check("R9 pa_o", pa_o, m_a);
      check("R9 pb_o", pb_o, m_b);
      check("R9 pc_o", pc_o, m_c);
      check("R4 pa_oe", pa_oe, {8{~m_cfg[4]}});
      check("R4 pb_oe", pb_oe, {8{~m_cfg[1]}});
      check("R4 pc_oe", pc_oe, {{4{~m_cfg[3]}}, {4{~m_cfg[0]}}});
      check("R10 bus_oe", {7'd0, bus_oe}, {7'd0, !cs_ni && !rd_ni});
      if (!cs_ni && !rd_ni) check("R8 bus_d_o", bus_do, m_rd(sel));
    end
  end

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); #1;
    cs_ni = 0; wr_ni = 0; sel = s; bus_di = d;
    @(negedge clk); #1;
    cs_ni = 1; wr_ni = 1;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] s, input logic [7:0] exp);
    @(negedge clk); #1;
    cs_ni = 0; rd_ni = 0; sel = s;
    #1 check(tag, bus_do, exp);
    cs_ni = 1; rd_ni = 1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG_CYC && !done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected <%0d cycles", cyc, WDOG_CYC);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 pa_oe in reset", pa_oe, 8'h00);
    check("R1 pc_o in reset", pc_o, 8'h00);
    #1 rst_ni = 1;
    rd_chk("R1 cfg after reset", 2'd3, 8'h9B);
    rd_chk("R8 pull-up pins on A", 2'd0, 8'hFF);
    // R9/R3: latch written while input, pins still read
    wr(2'd0, 8'h11);
    check("R9 A latch while input", pa_o, 8'h11);
    rd_chk("R8 A input reads pins", 2'd0, 8'hFF);
    // R4/R6: all outputs, latch cleared
    wr(2'd3, 8'h80);
    check("R6 A cleared", pa_o, 8'h00);
    check("R4 A oe", pa_oe, 8'hFF);
    check("R4 C oe", pc_oe, 8'hFF);
    wr(2'd0, 8'h5A); wr(2'd1, 8'hC3); wr(2'd2, 8'h96);
    rd_chk("R3 read A", 2'd0, 8'h5A);
    rd_chk("R3 read B", 2'd1, 8'hC3);
    rd_chk("R3 read C", 2'd2, 8'h96);
    // R2: writes without select ignored
    @(negedge clk); #1 cs_ni = 1; wr_ni = 0; sel = 2'd0; bus_di = 8'hFF;
    @(negedge clk); #1 rd_ni = 0;
    #1 check("R2 no oe without cs", {7'd0, bus_oe}, 8'h00);
    wr_ni = 1; rd_ni = 1;
    check("R2 A unchanged", pa_o, 8'h5A);
    // R7: bit set/reset
    wr(2'd3, 8'h01);
    check("R7 set bit0", pc_o, 8'h97);
    wr(2'd3, 8'h0E);
    check("R7 clear bit7", pc_o, 8'h17);
    wr(2'd3, 8'h0B);
    check("R7 set bit5", pc_o, 8'h37);
    rd_chk("R7 cfg unchanged", 2'd3, 8'h80);
    // R6/R8: C upper input, lower output
    pc_pin = 8'hA5;
    wr(2'd3, 8'h88);
    check("R6 C lower cleared, upper kept", pc_o, 8'h30);
    check("R6 B cleared", pb_o, 8'h00);
    check("R4 C nibble oe", pc_oe, 8'h0F);
    rd_chk("R8 C per nibble", 2'd2, 8'hA0);
    // R5: unused mode bits stored, no effect
    wr(2'd3, 8'hE6);
    rd_chk("R5 readback", 2'd3, 8'hE6);
    check("R5 A oe from bit4 only", pa_oe, 8'hFF);
    check("R5 B oe from bit1 only", pb_oe, 8'h00);
    check("R5 C oe", pc_oe, 8'hFF);
    // random traffic compared every clock
    for (int i = 0; i < 400; i++) begin
      @(negedge clk); #1;
      cs_ni  = ($urandom_range(0, 3) == 0);
      rd_ni  = $urandom_range(0, 1);
      wr_ni  = ($urandom_range(0, 2) == 0);
      sel    = 2'($urandom_range(0, 3));
      bus_di = 8'($urandom);
      pa_pin = 8'($urandom); pb_pin = 8'($urandom); pc_pin = 8'($urandom);
    end
    @(negedge clk); #1 cs_ni = 1; rd_ni = 1; wr_ni = 1;
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule